// File: doc/BRIEF.md
# Sample FIFO Bank with Sticky Overflow Status

This block holds four independent sample FIFOs, one for each sample sequencer, plus a single 32-bit status word that records which FIFOs have refused a write. Each FIFO has its own write strobe and data, its own read strobe, and show-ahead read data. A FIFO raises its full and empty flags from registers, so neither flag has a combinational path from the strobes.

A write that reaches a full FIFO, with no read on that FIFO in the same cycle, is thrown away. The stored samples and the pointers stay as they were, and the flag for that FIFO in the status word is set. The flag stays set until software clears it by writing a one to its bit over a small register bus (address, write enable, write data, combinational read data). A write of zero leaves a flag alone. If a new overflow and a clear hit the same bit in the same cycle, the set wins.

Top module: `smp_fifo_ovf_bank`

## Requirements
- R1: Each of the four FIFOs keeps 8 entries of 10 bits in first-in first-out order, independent of the others; `rd_data` slice n shows the oldest entry of FIFO n whenever that FIFO is not empty, and a read strobe on a non-empty FIFO removes that entry at the clock edge.
- R2: After reset every FIFO is empty; `full[n]` is 1 exactly when FIFO n holds 8 entries and `empty[n]` exactly when it holds none, both updated at the clock edge that changes the fill level.
- R3: A write to a full FIFO with no read of it in the same cycle is dropped: the contents and fill level do not change, and status bit n reads 1 from the next cycle.
- R4: A read and a write to a full FIFO in the same cycle are both accepted, the FIFO stays full, and no overflow flag is set.
- R5: The status word is read at byte address 0x10, with bit n holding the flag of FIFO n (bit 0 for FIFO 0, bit 3 for FIFO 3); any other address reads 0.
- R6: A register write to address 0x10 clears every flag whose bit in the write data is 1, visible in the next cycle; bits written 0 keep their value, and writes to other addresses change no flag.
- R7: When a clear and a new overflow reach the same flag in the same cycle, the flag remains 1.
- R8: All flags are 0 after reset; a set flag stays 1 through any number of further overflows until it is cleared.
- R9: Bits 31:4 of the status word always read 0, and writing ones to them has no effect.
- R10: A read strobe on an empty FIFO is ignored: the FIFO stays empty and a write in the same cycle is stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 4 | Write strobe, bit n for FIFO n |
| wr_data | input | 40 | Write data, bits 10n+9:10n for FIFO n |
| rd_en | input | 4 | Read strobe, bit n for FIFO n |
| rd_data | output | 40 | Oldest entry, bits 10n+9:10n for FIFO n |
| empty | output | 4 | FIFO n holds no entry |
| full | output | 4 | FIFO n holds 8 entries |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |

## Verification
The assertions take for granted only that the strobes and register inputs are known and stable at each rising edge after reset; they make no assumption about how often software clears flags or how hard the FIFOs are driven. The bench keeps within this by changing every input on the falling edge, and it drives reads on empty FIFOs, writes on full ones, and clears colliding with overflows on purpose, so the dropped-write, simultaneous read-write and set-over-clear paths are all reached both in directed phases and in a random phase.

// File: rtl/ovf_bank_pkg.sv
package ovf_bank_pkg;
   localparam int unsigned STATUS_WORD_W = 32;
   localparam int unsigned STATUS_OFS_DEF = 'h10;

   typedef logic [STATUS_WORD_W-1:0] status_word_t;

   function automatic int unsigned ptr_bits(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned WIDTH = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             empty,
   output logic             full,
   output logic             ovf_pulse
);
   localparam int unsigned AW = ovf_bank_pkg::ptr_bits(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sample_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sample_fifo: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [CW-1:0]    lvl_q, lvl_n;
   logic             full_q, empty_q;
   logic             do_rd, do_wr;

   assign do_rd     = rd_en && !empty_q;
   assign do_wr     = wr_en && (!full_q || do_rd);
   assign ovf_pulse = wr_en && !do_wr;

   always_comb begin
      lvl_n = lvl_q;
      case ({do_wr, do_rd})
         2'b10:   lvl_n = lvl_q + CW'(1);
         2'b01:   lvl_n = lvl_q - CW'(1);
         default: lvl_n = lvl_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q    <= '0;
         rp_q    <= '0;
         lvl_q   <= '0;
         full_q  <= 1'b0;
         empty_q <= 1'b1;
      end else begin
         if (do_wr) wp_q <= (wp_q == LAST) ? '0 : wp_q + AW'(1);
         if (do_rd) rp_q <= (rp_q == LAST) ? '0 : rp_q + AW'(1);
         lvl_q   <= lvl_n;
         full_q  <= (lvl_n == FULL_LVL);
         empty_q <= (lvl_n == '0);
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp_q] <= wr_data;
   end

   assign rd_data = mem[rp_q];
   assign empty   = empty_q;
   assign full    = full_q;

   // R3: a refused write leaves the fill level untouched
   p_drop_keeps_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full_q && !rd_en) |=> $stable(lvl_q) && full_q);
   // R4: read and write together on a full FIFO keep it full
   p_rw_full_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && full_q) |=> full_q);
   // R2: the two level flags never hold together
   p_full_empty_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_q && empty_q));
   // R10: a read of an empty FIFO without a write leaves it empty
   p_empty_read_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && empty_q) |=> empty_q);
endmodule

// File: rtl/ovf_status_reg.sv
module ovf_status_reg #(
   parameter int unsigned NUM = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] set_i,
   input  logic [NUM-1:0] clr_i,
   output logic [NUM-1:0] flags_o
);
   if (NUM < 1) begin : g_bad_num
      $error("ovf_status_reg: NUM must be at least 1");
   end

   logic [NUM-1:0] flag_q;

   for (genvar b = 0; b < NUM; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flag_q[b] <= 1'b0;
         else if (set_i[b])   flag_q[b] <= 1'b1;
         else if (clr_i[b])   flag_q[b] <= 1'b0;
      end

      // R3: an overflow event shows in the flag next cycle
      p_set_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> flag_q[b]);
      // R6: a clear without a competing set empties the flag
      p_clear_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && !set_i[b]) |=> !flag_q[b]);
      // R8: a set flag persists until a clear
      p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[b] && !clr_i[b]) |=> flag_q[b]);
      // R7: set beats clear in the same cycle
      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && set_i[b]) |=> flag_q[b]);
   end

   assign flags_o = flag_q;
endmodule

// File: rtl/smp_fifo_ovf_bank.sv
module smp_fifo_ovf_bank #(
   parameter int unsigned NUM_FIFO   = 4,
   parameter int unsigned DEPTH      = 8,
   parameter int unsigned WIDTH      = 10,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned STATUS_OFS = ovf_bank_pkg::STATUS_OFS_DEF
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_FIFO-1:0]       wr_en,
   input  logic [NUM_FIFO*WIDTH-1:0] wr_data,
   input  logic [NUM_FIFO-1:0]       rd_en,
   output logic [NUM_FIFO*WIDTH-1:0] rd_data,
   output logic [NUM_FIFO-1:0]       empty,
   output logic [NUM_FIFO-1:0]       full,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic                      reg_we,
   input  logic [31:0]               reg_wdata,
   output logic [31:0]               reg_rdata
);
   import ovf_bank_pkg::*;

   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(STATUS_OFS);

   if (NUM_FIFO < 1 || NUM_FIFO > STATUS_WORD_W) begin : g_bad_count
      $error("smp_fifo_ovf_bank: NUM_FIFO must fit the status word");
   end
   if (STATUS_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("smp_fifo_ovf_bank: STATUS_OFS outside address range");
   end

   logic [NUM_FIFO-1:0] ovf_set, ovf_clr, flags;
   logic                hit;

   assign hit = (reg_addr == OFS);

   for (genvar n = 0; n < NUM_FIFO; n++) begin : g_fifo
      sample_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_en[n]),
         .wr_data   (wr_data[n*WIDTH +: WIDTH]),
         .rd_en     (rd_en[n]),
         .rd_data   (rd_data[n*WIDTH +: WIDTH]),
         .empty     (empty[n]),
         .full      (full[n]),
         .ovf_pulse (ovf_set[n])
      );
   end

   assign ovf_clr = (reg_we && hit) ? reg_wdata[NUM_FIFO-1:0] : '0;

   ovf_status_reg #(.NUM(NUM_FIFO)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (ovf_set),
      .clr_i   (ovf_clr),
      .flags_o (flags)
   );

   status_word_t word;
   always_comb begin
      word = '0;
      word[NUM_FIFO-1:0] = flags;
   end

   assign reg_rdata = hit ? word : '0;

   // R9: the reserved part of the read word is never driven
   if (NUM_FIFO < STATUS_WORD_W) begin : g_rsv_chk
      always_comb begin
         p_reserved_zero_r9: assert (reg_rdata[31:NUM_FIFO] == '0);
      end
   end
   // R5: a read away from the status address returns zero
   p_other_addr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (reg_rdata == '0));
endmodule

// File: tb/smp_fifo_ovf_bank_tb.sv
module smp_fifo_ovf_bank_tb_top;
   localparam int NF = 4;
   localparam int DP = 8;
   localparam int WD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NF-1:0]    wr_en = '0;
   logic [NF*WD-1:0] wr_data = '0;
   logic [NF-1:0]    rd_en = '0;
   logic [NF*WD-1:0] rd_data;
   logic [NF-1:0]    empty, full;
   logic [7:0]       reg_addr = 8'h10;
   logic             reg_we = 1'b0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;

   always #4 clk = ~clk;

   smp_fifo_ovf_bank dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   logic [WD-1:0] mq [NF][$];
   logic [NF-1:0] mflags = '0;
   int checks = 0;
   int fails = 0;
   bit done = 0;
   string cur_req = "R8";

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      for (int i = 0; i < NF; i++) begin
         chk($sformatf("empty[%0d]", i), 32'(empty[i]), 32'(mq[i].size() == 0));
         chk($sformatf("full[%0d]", i), 32'(full[i]), 32'(mq[i].size() == DP));
         if (mq[i].size() > 0)
            chk($sformatf("rd_data[%0d]", i), 32'(rd_data[i*WD +: WD]), 32'(mq[i][0]));
      end
      chk("reg_rdata", reg_rdata, (reg_addr == 8'h10) ? {28'b0, mflags} : 32'b0);
   endtask

   task automatic idle();
      wr_en = '0; rd_en = '0; reg_we = 1'b0; reg_wdata = '0; reg_addr = 8'h10;
   endtask

   task automatic cycle();
      logic [NF-1:0] drd, dwr, ovf, clr;
      for (int i = 0; i < NF; i++) begin
         drd[i] = rd_en[i] && (mq[i].size() > 0);
         dwr[i] = wr_en[i] && ((mq[i].size() < DP) || drd[i]);
         ovf[i] = wr_en[i] && !dwr[i];
      end
      clr = (reg_we && reg_addr == 8'h10) ? reg_wdata[NF-1:0] : '0;
      @(posedge clk);
      for (int i = 0; i < NF; i++) begin
         if (drd[i]) void'(mq[i].pop_front());
         if (dwr[i]) mq[i].push_back(wr_data[i*WD +: WD]);
      end
      mflags = (mflags & ~clr) | ovf;
      @(negedge clk);
      compare();
   endtask

   task automatic push(input int f, input logic [WD-1:0] d);
      idle(); wr_en[f] = 1'b1; wr_data[f*WD +: WD] = d; cycle();
   endtask

   task automatic pop(input int f);
      idle(); rd_en[f] = 1'b1; cycle();
   endtask

   task automatic regwr(input logic [7:0] a, input logic [31:0] d);
      idle(); reg_we = 1'b1; reg_addr = a; reg_wdata = d; cycle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R8"; compare();           // reset state: empty, flags 0

      cur_req = "R1";
      push(0, 10'h3A1); push(0, 10'h055); push(2, 10'h2FF); push(0, 10'h100);
      pop(0); pop(0); pop(2); pop(0);

      cur_req = "R10";
      pop(1);
      idle(); rd_en[0] = 1'b1; wr_en[0] = 1'b1; wr_data[9:0] = 10'h1C3; cycle();
      pop(0);

      cur_req = "R2";
      for (int k = 0; k < DP; k++) push(1, 10'(k * 37 + 5));

      cur_req = "R3";
      push(1, 10'h3FF);
      idle(); cycle();

      cur_req = "R8";
      push(1, 10'h2AA); push(1, 10'h2AB);

      cur_req = "R4";
      for (int k = 0; k < DP; k++) push(3, 10'(k + 200));
      idle(); wr_en[3] = 1'b1; rd_en[3] = 1'b1; wr_data[39:30] = 10'h0F0; cycle();
      idle(); cycle();

      cur_req = "R5";
      idle(); reg_addr = 8'h14; cycle();
      idle(); reg_addr = 8'h00; cycle();

      cur_req = "R6";
      regwr(8'h10, 32'h0);
      regwr(8'h14, 32'hF);
      regwr(8'h10, 32'h2);

      cur_req = "R7";
      push(1, 10'h111);
      idle(); wr_en[1] = 1'b1; reg_we = 1'b1; reg_wdata = 32'h2; cycle();

      cur_req = "R9";
      regwr(8'h10, 32'hFFFF_FFF0);
      regwr(8'h10, 32'hFFFF_FFFF);

      cur_req = "R1";
      for (int k = 0; k < 400; k++) begin
         idle();
         wr_en = 4'($urandom);
         rd_en = 4'($urandom);
         wr_data = {$urandom, $urandom};
         if (($urandom % 8) == 0) begin
            reg_we = 1'b1; reg_wdata = $urandom;
         end
         if (($urandom % 8) == 0) reg_addr = 8'($urandom);
         cycle();
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule